// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each access of a four-beat burst on a synchronous memory port. A beat with the step input low captures a full external base address. Each following beat with the step input high moves the two low address bits to the next position of the burst. The bits above them keep the captured value. The low bits follow one of two orders. In linear order they count upward and wrap modulo four. In interleaved order they are the captured low bits XORed with the beat count. The order pin is sampled only on the beat that captures a base.

A synchronous clock enable freezes the whole sequencer for as long as it is low. The step input does double duty: it starts new cycles and it advances bursts. A user can therefore present a fresh address on every beat, or present one address and let the block run through the other three.

A two-state machine controls the block. `ST_IDLE` is the state after reset, before any base has been captured. `ST_BURST` is the state once a base is held. The transitions are:
- LOAD: from either state to `ST_BURST`.
- STEP: from `ST_BURST` to `ST_BURST`, with the beat count advanced.
- WAIT: from `ST_IDLE` to `ST_IDLE`, taken on a step.
- FREEZE: from any state to the same state, taken while the enable is low.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset (active low) is asserted, and after its release with no beat yet, `cur_addr` is all zeros.
- R2: On an enabled beat with `step` low, `cur_addr` equals `base_addr` from the next clock on, and the beat count restarts at 0.
- R3: With `ilv_mode` low at load time (linear order), the k-th enabled step after a load gives `cur_addr[1:0]` = (base[1:0] + k) mod 4.
- R4: With `ilv_mode` high at load time (interleaved order), the k-th enabled step after a load gives `cur_addr[1:0]` = base[1:0] XOR (k mod 4).
- R5: Changes of `ilv_mode` on step beats have no effect. The order captured at load holds until the next load.
- R6: The fourth enabled step after a load returns `cur_addr` to the loaded base. Further steps repeat the same four-address cycle.
- R7: While `clk_en` is low, `cur_addr` does not change. Neither `step` nor `base_addr` has any effect, and a load is ignored.
- R8: Steps never alter `cur_addr[AW-1:2]`. Only a load changes those bits.
- R9: A step taken before any load since reset leaves `cur_addr` at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Synchronous enable; low freezes all state |
| step | input | 1 | 0 loads `base_addr`, 1 advances the burst |
| ilv_mode | input | 1 | 1 selects interleaved order, 0 linear; sampled on load |
| base_addr | input | AW | External base address |
| cur_addr | output | AW | Current burst address |

## Verification
Linear and interleaved bursts are run from every base with low bits 00, 01, 10 and 11. Bases 01 and 11 are the cases that tell the two orders apart; 00 gives the same sequence in both. Each burst is stepped a fifth time to show the wrap back to the base. A step before any load and a toggle of the order pin in mid-burst check that only a load starts a sequence or selects an order. Stalls with a conflicting load and a conflicting step present separate the enable from the step input.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } bst_state_e;

    typedef logic [BEAT_W-1:0] beat_t;

endpackage

// File: rtl/burst_fsm.sv
module burst_fsm
    import burst_addr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_en,
    input  logic       step,
    input  logic       ilv_mode,
    output bst_state_e state,
    output beat_t      beat_cnt,
    output logic       mode_q,
    output logic       load_en
);

    bst_state_e state_d;
    beat_t      cnt_d;
    logic       mode_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            beat_cnt <= '0;
            mode_q   <= 1'b0;
        end else begin
            state    <= state_d;
            beat_cnt <= cnt_d;
            mode_q   <= mode_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state;
        cnt_d   = beat_cnt;
        mode_d  = mode_q;
        load_en = 1'b0;
        if (clk_en) begin
            unique case (state)
                ST_IDLE: begin
                    if (!step) begin
                        state_d = ST_BURST;
                        cnt_d   = '0;
                        mode_d  = ilv_mode;
                        load_en = 1'b1;
                    end
                end
                ST_BURST: begin
                    if (!step) begin
                        cnt_d   = '0;
                        mode_d  = ilv_mode;
                        load_en = 1'b1;
                    end else begin
                        cnt_d = beat_cnt + beat_t'(1);
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/base_hold.sv
module base_hold #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [AW-1:0] base_addr,
    output logic [AW-1:0] base_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (load_en) begin
            base_q <= base_addr;
        end
    end

endmodule

// File: rtl/burst_low_map.sv
module burst_low_map
    import burst_addr_pkg::*;
(
    input  beat_t base_lo,
    input  beat_t beat_cnt,
    input  logic  mode_q,
    output beat_t low_out
);

    beat_t lin_lo;
    beat_t ilv_lo;

    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
        assign ilv_lo[b] = base_lo[b] ^ beat_cnt[b];
    end

    assign lin_lo  = base_lo + beat_cnt;
    assign low_out = mode_q ? ilv_lo : lin_lo;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          step,
    input  logic          ilv_mode,
    input  logic [AW-1:0] base_addr,
    output logic [AW-1:0] cur_addr
);

    localparam int UP_W = AW - BEAT_W;

    bst_state_e    state;
    beat_t         beat_cnt;
    logic          mode_q;
    logic          load_en;
    logic [AW-1:0] base_q;
    beat_t         low_bits;

    burst_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .step     (step),
        .ilv_mode (ilv_mode),
        .state    (state),
        .beat_cnt (beat_cnt),
        .mode_q   (mode_q),
        .load_en  (load_en)
    );

    base_hold #(.AW(AW)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .base_addr (base_addr),
        .base_q    (base_q)
    );

    burst_low_map u_map (
        .base_lo  (base_q[BEAT_W-1:0]),
        .beat_cnt (beat_cnt),
        .mode_q   (mode_q),
        .low_out  (low_bits)
    );

    assign cur_addr = {base_q[AW-1 -: UP_W], low_bits};

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
    import burst_addr_pkg::*;
#(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en,
    input logic          step,
    input logic [AW-1:0] base_addr,
    input logic [AW-1:0] cur_addr,
    input bst_state_e    state,
    input beat_t         beat_cnt,
    input logic          mode_q
);

    // R7
    hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(cur_addr));

    // R2
    load_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !step) |=> (cur_addr == $past(base_addr)));

    // R8
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && step) |=> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && step && !mode_q && state == ST_BURST)
            |=> (cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1)));

    // R6
    wrap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && step && state == ST_BURST && beat_cnt == 2'd3) |=> (beat_cnt == 2'd0));

    // R9
    idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && step && state == ST_IDLE) |=> (state == ST_IDLE && cur_addr == '0));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .step      (step),
    .base_addr (base_addr),
    .cur_addr  (cur_addr),
    .state     (state),
    .beat_cnt  (beat_cnt),
    .mode_q    (mode_q)
);

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;

    localparam int  AW     = 20;
    localparam time CLK_PD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b0;
    logic          step = 1'b1;
    logic          ilv_mode = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [AW-1:0] cur_addr;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PD/2) clk = ~clk;

    burst_addr_gen #(.AW(AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .step      (step),
        .ilv_mode  (ilv_mode),
        .base_addr (base_addr),
        .cur_addr  (cur_addr)
    );

    task automatic check(string req, logic [AW-1:0] exp);
        n_chk++;
        if (cur_addr !== exp) begin
            n_err++;
            $display("FAIL %s: cur_addr=%h expected=%h", req, cur_addr, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic tick(logic en, logic stp, logic md, logic [AW-1:0] b);
        clk_en = en; step = stp; ilv_mode = md; base_addr = b;
        @(negedge clk);
    endtask

    function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] b, int k, logic md);
        logic [1:0] kk;
        kk = 2'(k);
        return md ? {b[AW-1:2], b[1:0] ^ kk} : {b[AW-1:2], 2'(b[1:0] + kk)};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        tick(1'b0, 1'b1, 1'b0, '0);
        check("R1 in reset", '0);
        rst_n = 1'b1;
        tick(1'b0, 1'b1, 1'b0, 20'hABCDE);
        check("R1 after release", '0);
    endtask

    task automatic t_idle_step();
        tick(1'b1, 1'b1, 1'b1, 20'h12345);
        check("R9 idle step", '0);
        tick(1'b1, 1'b1, 1'b0, 20'h77777);
        check("R9 idle step again", '0);
    endtask

    task automatic t_burst(logic md, logic [AW-1:0] b);
        tick(1'b1, 1'b0, md, b);
        check("R2 load", b);
        for (int k = 1; k <= 5; k++) begin
            tick(1'b1, 1'b1, md, ~b);
            check(md ? "R4 interleaved beat" : "R3 linear beat", expect_addr(b, k, md));
            if (k == 4) check("R6 wrap to base", b);
            check("R8 upper bits", {b[AW-1:2], cur_addr[1:0]});
        end
    endtask

    task automatic t_mode_flip();
        logic [AW-1:0] b = 20'h0F0F1;
        tick(1'b1, 1'b0, 1'b0, b);
        check("R2 load linear", b);
        for (int k = 1; k <= 3; k++) begin
            tick(1'b1, 1'b1, 1'b1, '0);
            check("R5 mode ignored mid-burst", expect_addr(b, k, 1'b0));
        end
        b = 20'h30303;
        tick(1'b1, 1'b0, 1'b1, b);
        for (int k = 1; k <= 2; k++) begin
            tick(1'b1, 1'b1, 1'b0, '1);
            check("R5 interleave kept", expect_addr(b, k, 1'b1));
        end
    endtask

    task automatic t_stall();
        logic [AW-1:0] b = 20'h5A5A1;
        tick(1'b1, 1'b0, 1'b0, b);
        tick(1'b1, 1'b1, 1'b0, '0);
        check("R3 before stall", expect_addr(b, 1, 1'b0));
        tick(1'b0, 1'b0, 1'b1, 20'hFFFFF);
        check("R7 load ignored", expect_addr(b, 1, 1'b0));
        tick(1'b0, 1'b1, 1'b0, '0);
        check("R7 step ignored", expect_addr(b, 1, 1'b0));
        tick(1'b1, 1'b1, 1'b0, '0);
        check("R7 resume", expect_addr(b, 2, 1'b0));
    endtask

    initial begin
        #(CLK_PD * 100000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_idle_step();
        for (int lo = 0; lo < 4; lo++) begin
            t_burst(1'b0, {18'h2B3C7, 2'(lo)});
            t_burst(1'b1, {18'h1D0E5, 2'(lo)});
        end
        t_mode_flip();
        t_stall();
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule